// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Critical-Word-First Refill

This block sits between an instruction fetch port and a pipelined memory read master. It keeps a direct-mapped store of 32-byte lines (eight 32-bit words) and returns the addressed instruction word in the same cycle as the request when the line is present and valid. The fetch address splits into three fields. The upper bits form the tag. The line index width follows from the cache size alone. The lowest five bits are the byte offset, and bits 4..2 of it select the word.

On a miss the block claims the line and starts a refill. The refill begins at the missed word and wraps around the line. A new read is issued every cycle the memory accepts one, without waiting for earlier data to come back. The first returned word goes straight to the fetch port. The rest of the line is written as it arrives, and the fetch port stays stalled until the line is complete. A lookup flagged with a check error is treated as a miss and refetched rather than corrected. Software-driven maintenance can drop a single indexed line or sweep every line invalid, one line per cycle.

Top module: `icache_cwf`

## Requirements
- R1: A fetch whose line is valid and whose tag matches returns the stored word with `fetch_ready` high in the same cycle as the request.
- R2: A miss issues exactly eight reads for the line. The upper address bits come from the fetch, and the word field (bits 4..2) starts at the missed word and increments modulo 8. The low two bits are zero.
- R3: With `mem_waitrequest` low, the eight refill reads are accepted in eight consecutive cycles, before all of their data has returned.
- R4: The first word returned by a refill is presented on `fetch_data` with `fetch_ready` high in the cycle its `mem_rvalid` arrives, before the line is complete.
- R5: While a refill is in progress, no further fetch completes until the last word of the line has returned. After that, the other words of the line hit.
- R6: While `mem_read` is high and `mem_waitrequest` is high, `mem_read` stays high and `mem_addr` does not change in the next cycle.
- R7: A one-cycle `inv_line_req` makes the line at `inv_line_index` miss on its next fetch. Lines at other indices keep hitting with their old contents.
- R8: A one-cycle `inv_all_req` clears every line, one per cycle. `fetch_ready` stays low for the whole sweep, and every line misses afterwards.
- R9: A fetch that would hit but arrives with `lookup_err` high is refetched from memory, and the fresh memory word is returned.
- R10: After reset all lines are invalid, `mem_read` is low and `fetch_ready` is low while no fetch is requested.
- R11: Two addresses with the same index and different tags evict each other, so alternating between them misses every time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | input | 1 | Fetch request, held until `fetch_ready` |
| fetch_addr | input | ADDR_W-2 | Word-aligned fetch address, byte-address bits ADDR_W-1..2 |
| lookup_err | input | 1 | Check error flagged on this lookup; forces a refetch |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Instruction word, valid with `fetch_ready` |
| inv_line_req | input | 1 | Invalidate one line (single-cycle pulse) |
| inv_line_index | input | IDX_W | Index of the line to invalidate |
| inv_all_req | input | 1 | Invalidate all lines (single-cycle pulse) |
| mem_read | output | 1 | Read request to memory |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_waitrequest | input | 1 | Memory is not accepting the read this cycle |
| mem_rvalid | input | 1 | Read data valid, returned in request order |
| mem_rdata | input | 32 | Read data |

## Verification
The bench's memory model gives each address a value that depends on a changeable salt. A stale valid bit therefore shows at the ports as a word carrying an old salt, and it shows in the same cycle as the request. A missed invalidate shows the same way. A wrong index, tag or wrap pointer shows up as a wrong address in the logged read sequence, and a wrong data-array write shows up on the first later hit to that word. Losing the first-word forward shows as a fetch that completes only after all eight reads have been accepted. Losing back-to-back issue shows as gaps in the cycle stamps of the accepted reads.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_FILL  = 2'd1,
      ST_SWEEP = 2'd2
   } fill_state_e;

   localparam int WORD_BITS  = 32;
   localparam int LINE_BYTES = 32;
   localparam int OFF_W      = 5;
   localparam int WSEL_W     = 3;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
   parameter int TAG_W = 22,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_valid,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             clr_a_en,
   input  logic [IDX_W-1:0] clr_a_idx,
   input  logic             clr_b_en,
   input  logic [IDX_W-1:0] clr_b_idx,
   input  logic             set_en,
   input  logic [IDX_W-1:0] set_idx
);
   localparam int NLINES = 1 << IDX_W;

   logic [TAG_W-1:0]  tags_q [NLINES];
   logic [NLINES-1:0] valid_q;
   logic [NLINES-1:0] line_clr;
   logic [NLINES-1:0] line_set;

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      assign line_clr[i] = (clr_a_en && clr_a_idx == IDX_W'(i)) ||
                           (clr_b_en && clr_b_idx == IDX_W'(i));
      assign line_set[i] = set_en && set_idx == IDX_W'(i);
   end

   // a clear on the same line in the same cycle wins over a set
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q <= '0;
      else        valid_q <= (valid_q | line_set) & ~line_clr;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tags_q[wr_idx] <= wr_tag;
   end

   assign rd_tag   = tags_q[rd_idx];
   assign rd_valid = valid_q[rd_idx];

   AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !line_clr[set_idx]) |=> valid_q[$past(set_idx)]) else $error("set lost"); // R5
   AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      clr_b_en |=> !valid_q[$past(clr_b_idx)]) else $error("clear lost"); // R7
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
   parameter int IDX_W  = 4,
   parameter int WSEL_W = 3,
   parameter int DW     = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WSEL_W-1:0] wr_wsel,
   input  logic [DW-1:0]     wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [WSEL_W-1:0] rd_wsel,
   output logic [DW-1:0]     rd_data
);
   localparam int DEPTH = 1 << (IDX_W + WSEL_W);

   logic [DW-1:0] words_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words_q[{wr_idx, wr_wsel}] <= wr_data;
   end

   assign rd_data = words_q[{rd_idx, rd_wsel}];
endmodule

// File: rtl/icache_refill.sv
module icache_refill
   import icache_pkg::*;
#(
   parameter int ADDR_W = 31,
   parameter int IDX_W  = 4,
   parameter int TAG_W  = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              miss_start,
   input  logic [TAG_W-1:0]  miss_tag,
   input  logic [IDX_W-1:0]  miss_idx,
   input  logic [WSEL_W-1:0] miss_word,
   input  logic              inv_all_req,
   input  logic              inv_line_req,
   input  logic [IDX_W-1:0]  inv_line_index,
   input  logic              mem_waitrequest,
   input  logic              mem_rvalid,
   output fill_state_e       state_o,
   output logic              mem_read,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              wr_en,
   output logic [IDX_W-1:0]  fill_idx,
   output logic [WSEL_W-1:0] wr_wsel,
   output logic              fwd_now,
   output logic              fill_set,
   output logic              sweep_clr,
   output logic [IDX_W-1:0]  sweep_idx
);
   fill_state_e       state_q;
   logic [TAG_W-1:0]  tag_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WSEL_W-1:0] w0_q;
   logic [WSEL_W:0]   issue_q;
   logic [WSEL_W-1:0] ret_q;
   logic              kill_q;
   logic              sweep_pend_q;
   logic [IDX_W-1:0]  sweep_q;

   logic accept, ret, last_ret, inv_hit;

   assign mem_read  = (state_q == ST_FILL) && !issue_q[WSEL_W];
   assign accept    = mem_read && !mem_waitrequest;
   assign ret       = (state_q == ST_FILL) && mem_rvalid;
   assign last_ret  = ret && (&ret_q);
   assign inv_hit   = inv_line_req && (inv_line_index == idx_q);
   assign mem_addr  = {tag_q, idx_q, w0_q + issue_q[WSEL_W-1:0], 2'b00};
   assign wr_en     = ret;
   assign fill_idx  = idx_q;
   assign wr_wsel   = w0_q + ret_q;
   assign fwd_now   = ret && (ret_q == '0);
   assign fill_set  = last_ret && !kill_q && !inv_hit;
   assign sweep_clr = (state_q == ST_SWEEP);
   assign sweep_idx = sweep_q;
   assign state_o   = state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         tag_q        <= '0;
         idx_q        <= '0;
         w0_q         <= '0;
         issue_q      <= '0;
         ret_q        <= '0;
         kill_q       <= 1'b0;
         sweep_pend_q <= 1'b0;
         sweep_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (inv_all_req) begin
                  state_q <= ST_SWEEP;
                  sweep_q <= '0;
               end else if (miss_start) begin
                  state_q      <= ST_FILL;
                  tag_q        <= miss_tag;
                  idx_q        <= miss_idx;
                  w0_q         <= miss_word;
                  issue_q      <= '0;
                  ret_q        <= '0;
                  kill_q       <= 1'b0;
                  sweep_pend_q <= 1'b0;
               end
            end
            ST_FILL: begin
               if (accept)      issue_q      <= issue_q + 1'b1;
               if (ret)         ret_q        <= ret_q + 1'b1;
               if (inv_hit)     kill_q       <= 1'b1;
               if (inv_all_req) sweep_pend_q <= 1'b1;
               if (last_ret) begin
                  state_q <= (sweep_pend_q || inv_all_req) ? ST_SWEEP : ST_IDLE;
                  sweep_q <= '0;
               end
            end
            ST_SWEEP: begin
               if (&sweep_q) state_q <= ST_IDLE;
               else          sweep_q <= sweep_q + 1'b1;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_READ_ONLY_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_FILL) |-> !mem_read) else $error("stray read"); // R10
   AST_NO_RETURN_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      ret |-> (issue_q > {1'b0, ret_q})) else $error("data before request"); // R3
endmodule

// File: rtl/icache_cwf.sv
module icache_cwf
   import icache_pkg::*;
#(
   parameter int ADDR_W      = 31,
   parameter int CACHE_BYTES = 512,
   localparam int NLINES     = CACHE_BYTES / LINE_BYTES,
   localparam int IDX_W      = $clog2(NLINES),
   localparam int TAG_W      = ADDR_W - OFF_W - IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fetch_req,
   input  logic [ADDR_W-1:2]    fetch_addr,
   input  logic                 lookup_err,
   output logic                 fetch_ready,
   output logic [WORD_BITS-1:0] fetch_data,
   input  logic                 inv_line_req,
   input  logic [IDX_W-1:0]     inv_line_index,
   input  logic                 inv_all_req,
   output logic                 mem_read,
   output logic [ADDR_W-1:0]    mem_addr,
   input  logic                 mem_waitrequest,
   input  logic                 mem_rvalid,
   input  logic [WORD_BITS-1:0] mem_rdata
);
   if (CACHE_BYTES < 512 || CACHE_BYTES > 65536 ||
       (CACHE_BYTES & (CACHE_BYTES - 1)) != 0) begin : g_bad_size
      $error("CACHE_BYTES must be a power of two from 512 to 65536");
   end
   if (ADDR_W > 32 || TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits or exceeds 32");
   end

   logic [TAG_W-1:0]     f_tag;
   logic [IDX_W-1:0]     f_idx;
   logic [WSEL_W-1:0]    f_word;
   logic [TAG_W-1:0]     rd_tag;
   logic                 rd_valid;
   logic [WORD_BITS-1:0] rd_data;
   fill_state_e          state;
   logic                 wr_en, fwd_now, fill_set, sweep_clr;
   logic [IDX_W-1:0]     fill_idx, sweep_idx;
   logic [WSEL_W-1:0]    wr_wsel;
   logic                 in_idle, maint, tag_hit, hit_ok, miss_start;

   assign f_tag  = fetch_addr[ADDR_W-1 -: TAG_W];
   assign f_idx  = fetch_addr[OFF_W +: IDX_W];
   assign f_word = fetch_addr[2 +: WSEL_W];

   assign in_idle    = (state == ST_IDLE);
   assign maint      = inv_line_req || inv_all_req;
   assign tag_hit    = rd_valid && (rd_tag == f_tag) && !lookup_err;
   assign hit_ok     = in_idle && fetch_req && !maint && tag_hit;
   assign miss_start = in_idle && fetch_req && !maint && !tag_hit;

   assign fetch_ready = hit_ok || (fwd_now && fetch_req);
   assign fetch_data  = fwd_now ? mem_rdata : rd_data;

   icache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) tags_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (f_idx),
      .rd_tag    (rd_tag),
      .rd_valid  (rd_valid),
      .wr_en     (miss_start),
      .wr_idx    (f_idx),
      .wr_tag    (f_tag),
      .clr_a_en  (miss_start || sweep_clr),
      .clr_a_idx (sweep_clr ? sweep_idx : f_idx),
      .clr_b_en  (inv_line_req),
      .clr_b_idx (inv_line_index),
      .set_en    (fill_set),
      .set_idx   (fill_idx)
   );

   icache_data_store #(.IDX_W(IDX_W), .WSEL_W(WSEL_W), .DW(WORD_BITS)) data_i (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_idx  (fill_idx),
      .wr_wsel (wr_wsel),
      .wr_data (mem_rdata),
      .rd_idx  (f_idx),
      .rd_wsel (f_word),
      .rd_data (rd_data)
   );

   icache_refill #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) refill_i (
      .clk             (clk),
      .rst_n           (rst_n),
      .miss_start      (miss_start),
      .miss_tag        (f_tag),
      .miss_idx        (f_idx),
      .miss_word       (f_word),
      .inv_all_req     (inv_all_req),
      .inv_line_req    (inv_line_req),
      .inv_line_index  (inv_line_index),
      .mem_waitrequest (mem_waitrequest),
      .mem_rvalid      (mem_rvalid),
      .state_o         (state),
      .mem_read        (mem_read),
      .mem_addr        (mem_addr),
      .wr_en           (wr_en),
      .fill_idx        (fill_idx),
      .wr_wsel         (wr_wsel),
      .fwd_now         (fwd_now),
      .fill_set        (fill_set),
      .sweep_clr       (sweep_clr),
      .sweep_idx       (sweep_idx)
   );

   AST_HOLD_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read && mem_waitrequest) |=> (mem_read && $stable(mem_addr))) else $error("addr moved"); // R6
   AST_WRAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_read && !mem_waitrequest) |=>
      (!mem_read || (mem_addr[4:2] == ($past(mem_addr[4:2]) + 3'd1)))) else $error("bad wrap"); // R2
   AST_SWEEP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SWEEP) |-> !fetch_ready) else $error("fetch during sweep"); // R8
   AST_FILL_ONLY_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_FILL) && fetch_ready) |-> mem_rvalid) else $error("early completion"); // R5
   AST_ALIGNED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      mem_read |-> (mem_addr[1:0] == 2'b00)) else $error("unaligned read"); // R2
endmodule

// File: tb/icache_cwf_tb_top.sv
module icache_cwf_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 31;
   localparam int IDX_W      = 4;
   localparam int NLINES     = 16;
   localparam int LAT        = 2;
   localparam int WDOG       = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              fetch_req = 1'b0;
   logic [ADDR_W-1:2] fetch_addr = '0;
   logic              lookup_err = 1'b0;
   logic              fetch_ready;
   logic [31:0]       fetch_data;
   logic              inv_line_req = 1'b0;
   logic [IDX_W-1:0]  inv_line_index = '0;
   logic              inv_all_req = 1'b0;
   logic              mem_read;
   logic [ADDR_W-1:0] mem_addr;
   logic              mem_waitrequest;
   logic              mem_rvalid;
   logic [31:0]       mem_rdata;

   int          checks = 0;
   int          failures = 0;
   logic [31:0] salt = 32'h1357_9BDF;
   logic        stall_en = 1'b0;
   int          cyc = 0;
   int          nlog = 0;
   logic [ADDR_W-1:0] log_a [256];
   int                log_c [256];
   logic              p_v [LAT];
   logic [ADDR_W-1:0] p_a [LAT];

   always #(CLK_PERIOD/2) clk = ~clk;

   icache_cwf #(.ADDR_W(ADDR_W), .CACHE_BYTES(512)) dut_i (
      .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
      .lookup_err(lookup_err), .fetch_ready(fetch_ready), .fetch_data(fetch_data),
      .inv_line_req(inv_line_req), .inv_line_index(inv_line_index),
      .inv_all_req(inv_all_req), .mem_read(mem_read), .mem_addr(mem_addr),
      .mem_waitrequest(mem_waitrequest), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] memword(input logic [ADDR_W-1:0] a);
      return ({1'b0, a} * 32'h9E37_79B1) ^ salt;
   endfunction

   // memory model: fixed latency, in-order, optional wait pattern
   assign mem_waitrequest = stall_en && ((cyc % 3) != 0);
   assign mem_rvalid      = p_v[LAT-1];
   assign mem_rdata       = memword(p_a[LAT-1]);

   always @(posedge clk) begin
      cyc <= cyc + 1;
      p_v[0] <= rst_n && mem_read && !mem_waitrequest;
      p_a[0] <= mem_addr;
      for (int i = 1; i < LAT; i++) begin
         p_v[i] <= p_v[i-1];
         p_a[i] <= p_a[i-1];
      end
      if (mem_read && !mem_waitrequest && nlog < 256) begin
         log_a[nlog] <= mem_addr;
         log_c[nlog] <= cyc;
         nlog <= nlog + 1;
      end
      if (cyc > WDOG) begin
         failures++;
         $display("FAIL watchdog expired at cycle %0d (actual hung, expected finish)", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_fetch(input logic [ADDR_W-1:0] a, input logic err,
                           output logic [31:0] d, output int waits, output int logs_at);
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = a[ADDR_W-1:2]; lookup_err = err; waits = 0;
      #1;
      while (!fetch_ready) begin
         @(negedge clk); waits++; #1;
      end
      d = fetch_data; logs_at = nlog;
      @(negedge clk);
      fetch_req = 1'b0; lookup_err = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   localparam logic [31:0] VEC [9] = '{
      32'h0000_0104,  // miss, idx 8 word 1
      32'h0000_0101,  // hit, same line word 0
      32'h0000_011D,  // hit, word 7
      32'h0000_0220,  // miss, idx 1 tag 1
      32'h0000_0020,  // miss, idx 1 tag 0 evicts
      32'h0000_0224,  // miss, evicted again
      32'h0000_0109,  // hit, idx 8 untouched
      32'h7FFF_FFFC,  // miss, top line word 7
      32'h7FFF_FFE1   // hit
   };

   initial begin
      logic [31:0] d, d300, d448;
      int w, la, b;
      logic [ADDR_W-1:0] a;
      repeat (3) @(negedge clk);
      #1;
      chk(!fetch_ready, "R10 fetch_ready after reset", {31'd0, fetch_ready}, 32'd0);
      chk(!mem_read, "R10 mem_read after reset", {31'd0, mem_read}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      chk(!mem_read && nlog == 0, "R10 no reads while idle", nlog, 32'd0);

      // table-driven hit/miss walk
      foreach (VEC[k]) begin
         a = VEC[k][30:0] & ~31'd3;
         do_fetch(a, 1'b0, d, w, la);
         chk(d == memword(a), VEC[k][0] ? "R1 hit data" : "R11 miss data", d, memword(a));
         chk((w == 0) == VEC[k][0], VEC[k][0] ? "R1 hit same cycle" : "R11 miss stalls",
             w, {31'd0, VEC[k][0]});
         idle(12);
      end

      // R2 R3 R4: wrap order, back-to-back issue, early forward
      b = nlog;
      do_fetch(31'h314, 1'b0, d, w, la);
      chk(d == memword(31'h314), "R4 forwarded word", d, memword(31'h314));
      chk(la - b < 8, "R4 forward before line done", la - b, 32'd8);
      // R5: next word of the same line stalls until the line is complete
      do_fetch(31'h300, 1'b0, d300, w, la);
      chk(la - b == 8, "R5 stalled until full line", la - b, 32'd8);
      chk(d300 == memword(31'h300), "R5 data after fill", d300, memword(31'h300));
      idle(4);
      for (int i = 0; i < 8; i++) begin
         a = {26'h18, 3'(5 + i), 2'b00};
         chk(log_a[b+i] == a, "R2 wrap address", log_a[b+i], a);
      end
      chk(log_c[b+7] - log_c[b] == 7, "R3 back-to-back issue", log_c[b+7] - log_c[b], 32'd7);
      do_fetch(31'h318, 1'b0, d, w, la);
      chk(w == 0 && d == memword(31'h318), "R5 hit after fill", d, memword(31'h318));

      // R6: memory wait states
      stall_en = 1'b1;
      b = nlog;
      do_fetch(31'h448, 1'b0, d448, w, la);
      idle(30);
      stall_en = 1'b0;
      chk(d448 == memword(31'h448), "R6 data under wait", d448, memword(31'h448));
      chk(nlog - b == 8, "R6 read count", nlog - b, 32'd8);
      for (int i = 0; i < 8; i++) begin
         a = {26'h22, 3'(2 + i), 2'b00};
         chk(log_a[b+i] == a, "R6 address order under wait", log_a[b+i], a);
      end

      // R9: check error forces refetch
      salt = 32'hC0FF_EE11;
      do_fetch(31'h448, 1'b0, d, w, la);
      chk(w == 0 && d == d448, "R9 plain hit keeps old word", d, d448);
      b = nlog;
      do_fetch(31'h448, 1'b1, d, w, la);
      idle(12);
      chk(d == memword(31'h448), "R9 refetched word", d, memword(31'h448));
      chk(nlog - b == 8, "R9 line refilled", nlog - b, 32'd8);

      // R7: line invalidate
      salt = 32'h0BAD_F00D;
      @(negedge clk); inv_line_req = 1'b1; inv_line_index = 4'd2;
      @(negedge clk); inv_line_req = 1'b0;
      do_fetch(31'h448, 1'b0, d, w, la);
      idle(12);
      chk(w > 0 && d == memword(31'h448), "R7 invalidated line misses", d, memword(31'h448));
      do_fetch(31'h300, 1'b0, d, w, la);
      chk(w == 0 && d == d300, "R7 other line kept", d, d300);

      // R8: full invalidate sweep
      salt = 32'h5A5A_1234;
      @(negedge clk); inv_all_req = 1'b1;
      @(negedge clk); inv_all_req = 1'b0;
      do_fetch(31'h300, 1'b0, d, w, la);
      idle(12);
      chk(w >= NLINES - 2, "R8 sweep stalls fetch", w, NLINES - 2);
      chk(d == memword(31'h300), "R8 line refetched", d, memword(31'h300));
      do_fetch(31'h7FFF_FFE0, 1'b0, d, w, la);
      idle(12);
      chk(w > 0 && d == memword(31'h7FFF_FFE0), "R8 last line cleared", d, memword(31'h7FFF_FFE0));

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule